// File: doc/BRIEF.md
# Multi-CPU device interrupt router

The block collects level interrupt requests from up to 64 device sources into one shared request vector and routes them to a small set of CPUs. Each CPU owns a 64-bit enable mask. Its pending vector is the request vector ANDed with that mask, and a level interrupt line is driven to the CPU while any pending bit is set. Device sources set or clear single request bits by index. Software programs the masks and inspects the request and pending vectors through a 64-bit register port.

Pending vectors are held in registers. They are rebuilt from the next-state mask and request values at every edge, so a mask write, a request set and a request clear are all reflected in the same cycle. Registers can be reached two ways. One is a direct map with 64-byte spacing. The other is a banked view in which one offset bit selects the mask bank or the pending bank and a 6-bit field in the offset picks the CPU. Illegal accesses return a one-cycle error pulse and change nothing.

Top module: `dir_router`

## Requirements
- R1: After reset the request vector, all masks and all pending vectors read 0, and every `irq_o` bit and `err_o` are low.
- R2: For every CPU c, pending c equals mask c AND the request vector after every edge. This holds on mask writes, request sets and request clears.
- R3: A device set pulse with index i sets request bit i. If a set and a clear of the same index arrive in one cycle, the set wins.
- R4: A device clear pulse with index i clears request bit i. A clear of a bit that is already 0 is spurious and leaves the request vector unchanged.
- R5: `irq_o[c]` equals the OR-reduction of pending c, delayed by one clock.
- R6: Direct map: the register index is the offset shifted right by 6. Index 0 is the request vector, index 8+c is mask c, and index 16+c is pending c. Read data appears on `rdata_o` in the cycle after the access.
- R7: Banked map: offset bit 12 selects mask bank and offset bit 13 selects pending bank. The CPU number comes from offset bits [9:4]. Bit 12 takes priority when both are set. Direct decoding is used only when both bits are 0.
- R8: Only `size_i` = 3 (8-byte access) is legal. Any other size is an error.
- R9: Writes to the request vector or to a pending register are errors.
- R10: An access to an unmapped index, or to a banked CPU number of N_CPU or above, is an error. Any error pulses `err_o` high for one cycle in the cycle after the access, leaves all state unchanged, and returns `rdata_o` = 0.
- R11: A mask write that enables a bit whose request is active raises that CPU's `irq_o`. A mask write that disables the only pending bit lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Byte offset within the block |
| bus_size_i | input | 2 | Access size as log2 bytes; 3 = 8 bytes |
| bus_wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid the cycle after a read |
| err_o | output | 1 | One-cycle error pulse for an illegal access |
| dev_set_i | input | 1 | Raise a device request |
| dev_set_idx_i | input | 6 | Index of the request to raise |
| dev_clr_i | input | 1 | Withdraw a device request |
| dev_clr_idx_i | input | 6 | Index of the request to withdraw |
| irq_o | output | 4 | Level interrupt line per CPU |

## Verification
The assertions assume that `bus_req_i`, `dev_set_i` and `dev_clr_i` are single-cycle strobes sampled at the rising edge. They also assume that an index is meaningful only while its strobe is high. Under those assumptions, a clear is spurious only when the addressed bit is 0 and no set arrives in the same cycle. The stimulus drives every input at the falling edge and returns each strobe to 0 one cycle later. Register accesses and device events are never issued in the same cycle, except in a directed collision case. Because of this, read data is always compared against a model state that device traffic has not moved.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_REQ  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_PEND = 2'd3
  } sel_e;

  localparam logic [1:0] SIZE_DWORD = 2'd3;
  localparam int         MASK_BASE  = 8;
  localparam int         PEND_BASE  = 16;
endpackage

// File: rtl/dir_decode.sv
module dir_decode
  import dir_pkg::*;
#(
  parameter int N_CPU         = 4,
  parameter int AW            = 16,
  parameter int MASK_BANK_BIT = 12,
  parameter int PEND_BANK_BIT = 13,
  parameter int BANK_LSB      = 4,
  parameter int BANK_W        = 6,
  parameter int REG_SHIFT     = 6,
  parameter int CPU_W         = 2
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [1:0]       size_i,
  input  logic             we_i,
  output sel_e             sel_o,
  output logic [CPU_W-1:0] cpu_o,
  output logic             illegal_o
);
  localparam int IDX_W = AW - REG_SHIFT;

  logic [BANK_W-1:0] bank_idx;
  logic [IDX_W-1:0]  reg_idx;
  logic              unused_low;
  int                bidx, ridx;

  assign bank_idx   = addr_i[BANK_LSB +: BANK_W];
  assign reg_idx    = addr_i[AW-1:REG_SHIFT];
  assign unused_low = ^addr_i[BANK_LSB-1:0];
  assign bidx       = int'(bank_idx);
  assign ridx       = int'(reg_idx);

  always_comb begin
    sel_o = SEL_NONE;
    cpu_o = '0;
    if (addr_i[MASK_BANK_BIT]) begin
      if (bidx < N_CPU) begin
        sel_o = SEL_MASK;
        cpu_o = CPU_W'(bidx);
      end
    end else if (addr_i[PEND_BANK_BIT]) begin
      if (bidx < N_CPU) begin
        sel_o = SEL_PEND;
        cpu_o = CPU_W'(bidx);
      end
    end else if (ridx == 0) begin
      sel_o = SEL_REQ;
    end else if (ridx >= MASK_BASE && ridx < MASK_BASE + N_CPU) begin
      sel_o = SEL_MASK;
      cpu_o = CPU_W'(ridx - MASK_BASE);
    end else if (ridx >= PEND_BASE && ridx < PEND_BASE + N_CPU) begin
      sel_o = SEL_PEND;
      cpu_o = CPU_W'(ridx - PEND_BASE);
    end
  end

  assign illegal_o = (size_i != SIZE_DWORD) || (sel_o == SEL_NONE) ||
                     (we_i && (sel_o != SEL_MASK));
endmodule

// File: rtl/dir_req_vec.sv
module dir_req_vec #(
  parameter int VEC_W = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [VEC_W-1:0] req_o,
  output logic [VEC_W-1:0] req_nxt_o
);
  logic [VEC_W-1:0] req_q;

  // clear applies only to an active bit; a set of the same index overrides it
  always_comb begin
    req_nxt_o = req_q;
    if (clr_i && req_q[clr_idx_i]) req_nxt_o[clr_idx_i] = 1'b0;
    if (set_i)                     req_nxt_o[set_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_nxt_o;
  end

  assign req_o = req_q;
endmodule

// File: rtl/dir_cpu_slice.sv
module dir_cpu_slice #(
  parameter int VEC_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [VEC_W-1:0] mask_wdata_i,
  input  logic [VEC_W-1:0] req_nxt_i,
  output logic [VEC_W-1:0] mask_o,
  output logic [VEC_W-1:0] pend_o,
  output logic             irq_o
);
  logic [VEC_W-1:0] mask_q, mask_nxt, pend_q;
  logic             irq_q;

  assign mask_nxt = mask_we_i ? mask_wdata_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      pend_q <= mask_nxt & req_nxt_i;
      irq_q  <= |pend_q;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dir_router.sv
module dir_router
  import dir_pkg::*;
#(
  parameter int N_CPU         = 4,
  parameter int VEC_W         = 64,
  parameter int AW            = 16,
  parameter int MASK_BANK_BIT = 12,
  parameter int PEND_BANK_BIT = 13,
  parameter int IDX_W         = $clog2(VEC_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [1:0]       bus_size_i,
  input  logic [VEC_W-1:0] bus_wdata_i,
  output logic [VEC_W-1:0] rdata_o,
  output logic             err_o,
  input  logic             dev_set_i,
  input  logic [IDX_W-1:0] dev_set_idx_i,
  input  logic             dev_clr_i,
  input  logic [IDX_W-1:0] dev_clr_idx_i,
  output logic [N_CPU-1:0] irq_o
);
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

  sel_e                        sel;
  logic [CPU_W-1:0]            cpu;
  logic                        illegal, acc_ok;
  logic [VEC_W-1:0]            req_vec, req_nxt, rd_d, rdata_q;
  logic [N_CPU-1:0][VEC_W-1:0] mask_all, pend_all;
  logic                        err_q;

  dir_decode #(
    .N_CPU(N_CPU), .AW(AW), .MASK_BANK_BIT(MASK_BANK_BIT),
    .PEND_BANK_BIT(PEND_BANK_BIT), .BANK_LSB(4), .BANK_W(6),
    .REG_SHIFT(6), .CPU_W(CPU_W)
  ) u_dec (
    .addr_i(bus_addr_i), .size_i(bus_size_i), .we_i(bus_we_i),
    .sel_o(sel), .cpu_o(cpu), .illegal_o(illegal)
  );

  assign acc_ok = bus_req_i && !illegal;

  dir_req_vec #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(dev_set_i), .set_idx_i(dev_set_idx_i),
    .clr_i(dev_clr_i), .clr_idx_i(dev_clr_idx_i),
    .req_o(req_vec), .req_nxt_o(req_nxt)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic mask_we;
    assign mask_we = acc_ok && bus_we_i && (sel == SEL_MASK) && (int'(cpu) == c);
    dir_cpu_slice #(.VEC_W(VEC_W)) u_slice (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .mask_we_i(mask_we), .mask_wdata_i(bus_wdata_i),
      .req_nxt_i(req_nxt),
      .mask_o(mask_all[c]), .pend_o(pend_all[c]), .irq_o(irq_o[c])
    );
  end

  always_comb begin
    rd_d = '0;
    if (acc_ok && !bus_we_i) begin
      unique case (sel)
        SEL_REQ:  rd_d = req_vec;
        SEL_MASK: rd_d = mask_all[cpu];
        SEL_PEND: rd_d = pend_all[cpu];
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_d;
      err_q   <= bus_req_i && illegal;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/dir_router_chk.sv
module dir_router_chk #(
  parameter int N_CPU = 4,
  parameter int VEC_W = 64,
  parameter int IDX_W = 6
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        bus_req_i,
  input logic                        err_o,
  input logic                        dev_set_i,
  input logic [IDX_W-1:0]            dev_set_idx_i,
  input logic                        dev_clr_i,
  input logic [IDX_W-1:0]            dev_clr_idx_i,
  input logic [VEC_W-1:0]            req_vec,
  input logic [N_CPU-1:0][VEC_W-1:0] mask_all,
  input logic [N_CPU-1:0][VEC_W-1:0] pend_all,
  input logic [N_CPU-1:0]            irq_o
);
  for (genvar c = 0; c < N_CPU; c++) begin : g_chk
    assert_pend_eq_mask_and_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_all[c] == (mask_all[c] & req_vec));
    assert_irq_follows_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> irq_o[c] == (|$past(pend_all[c])));
  end

  assert_set_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_set_i |=> req_vec[$past(dev_set_idx_i)]);

  assert_clear_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_clr_i && !dev_set_i) |=> !req_vec[$past(dev_clr_idx_i)]);

  assert_spurious_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_clr_i && !dev_set_i && !req_vec[dev_clr_idx_i]) |=> req_vec == $past(req_vec));

  assert_err_keeps_masks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> mask_all == $past(mask_all));

  assert_err_needs_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(bus_req_i));
endmodule

bind dir_router dir_router_chk #(.N_CPU(N_CPU), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .err_o(err_o),
  .dev_set_i(dev_set_i), .dev_set_idx_i(dev_set_idx_i),
  .dev_clr_i(dev_clr_i), .dev_clr_idx_i(dev_clr_idx_i),
  .req_vec(req_vec), .mask_all(mask_all), .pend_all(pend_all), .irq_o(irq_o)
);

// File: tb/tb_dir_router.sv
module tb_dir_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = 2'd3;
  logic [63:0] bus_wdata = '0;
  logic [63:0] rdata;
  logic        err;
  logic        dset = 1'b0, dclr = 1'b0;
  logic [5:0]  dset_idx = '0, dclr_idx = '0;
  logic [3:0]  irq;

  int checks = 0, errors = 0;
  logic [63:0] m_req;
  logic [63:0] m_mask [4];

  always #2 clk = ~clk;

  dir_router dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_size_i(bus_size), .bus_wdata_i(bus_wdata),
    .rdata_o(rdata), .err_o(err), .dev_set_i(dset), .dev_set_idx_i(dset_idx),
    .dev_clr_i(dclr), .dev_clr_idx_i(dclr_idx), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] a_direct(input int idx); return 16'(idx << 6); endfunction
  function automatic logic [15:0] a_bmask(input int c); return 16'h1000 | 16'(c << 4); endfunction
  function automatic logic [15:0] a_bpend(input int c); return 16'h2000 | 16'(c << 4); endfunction

  // independent model of the register map
  function automatic void model_acc(input bit we, input logic [15:0] a, input logic [1:0] sz,
                                    input logic [63:0] wd, output logic [63:0] rd, output bit er);
    int kind = 0;
    int c = 0;
    if (a[12]) begin
      c = int'(a[9:4]);
      if (c < 4) kind = 2;
    end else if (a[13]) begin
      c = int'(a[9:4]);
      if (c < 4) kind = 3;
    end else begin
      int idx = int'(a[15:6]);
      if (idx == 0) kind = 1;
      else if (idx >= 8 && idx < 12) begin kind = 2; c = idx - 8; end
      else if (idx >= 16 && idx < 20) begin kind = 3; c = idx - 16; end
    end
    er = (sz != 2'd3) || (kind == 0) || (we && kind != 2);
    rd = '0;
    if (!er && !we) begin
      if (kind == 1) rd = m_req;
      else if (kind == 2) rd = m_mask[c];
      else rd = m_mask[c] & m_req;
    end
    if (!er && we) m_mask[c] = wd;
  endfunction

  task automatic bus(input string tag, input bit we, input logic [15:0] a,
                     input logic [1:0] sz, input logic [63:0] wd);
    logic [63:0] erd;
    bit          eer;
    model_acc(we, a, sz, wd, erd, eer);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(posedge clk); #1;
    bus_req = 1'b0;
    chk({tag, " rdata"}, rdata, erd);
    chk({tag, " err"}, 64'(err), 64'(eer));
  endtask

  task automatic dev(input bit s, input int si, input bit c, input int ci);
    @(negedge clk);
    dset = s; dset_idx = 6'(si); dclr = c; dclr_idx = 6'(ci);
    @(posedge clk); #1;
    dset = 1'b0; dclr = 1'b0;
    if (c) m_req[ci] = 1'b0;
    if (s) m_req[si] = 1'b1;
  endtask

  task automatic chk_irq(input string tag);
    logic [3:0] e;
    @(posedge clk); #1;
    for (int c = 0; c < 4; c++) e[c] = |(m_mask[c] & m_req);
    chk(tag, 64'(irq), 64'(e));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    m_req = '0;
    for (int c = 0; c < 4; c++) m_mask[c] = '0;
    #9 rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 err", 64'(err), 64'h0);
    bus("R1 req", 0, a_direct(0), 2'd3, 0);
    bus("R1 mask3", 0, a_direct(11), 2'd3, 0);
    bus("R1 pend0", 0, a_direct(16), 2'd3, 0);

    // R6 direct map, R11 enabling an active request
    dev(1, 5, 0, 0);
    chk_irq("R3 no mask no irq");
    bus("R6 req read", 0, a_direct(0), 2'd3, 0);
    bus("R11 mask0 write", 1, a_direct(8), 2'd3, 64'h20);
    chk_irq("R11 irq raised");
    bus("R6 pend0 read", 0, a_direct(16), 2'd3, 0);
    bus("R11 mask0 disable", 1, a_direct(8), 2'd3, 64'h0);
    chk_irq("R11 irq withdrawn");

    // R4 spurious clear, R3 set beats clear
    bus("R2 mask2", 1, a_bmask(2), 2'd3, 64'hffff_ffff_ffff_ffff);
    dev(0, 0, 1, 40);
    bus("R4 spurious", 0, a_direct(0), 2'd3, 0);
    dev(1, 63, 1, 63);
    bus("R3 collision", 0, a_direct(0), 2'd3, 0);
    dev(0, 0, 1, 5);
    bus("R4 clear", 0, a_bpend(2), 2'd3, 0);
    chk_irq("R5 irq2");

    // R7 banked views and priority
    bus("R7 both bits", 0, 16'h3000 | 16'(2 << 4), 2'd3, 0);
    bus("R7 pend bank", 0, a_bpend(2), 2'd3, 0);
    bus("R10 bank cpu4", 0, a_bmask(4), 2'd3, 0);
    // R8 size, R9 read-only, R10 unmapped
    bus("R8 size2", 1, a_direct(9), 2'd2, 64'h1);
    bus("R8 check mask1", 0, a_direct(9), 2'd3, 0);
    bus("R9 write pend", 1, a_direct(17), 2'd3, 64'h1);
    bus("R9 write req", 1, a_direct(0), 2'd3, 64'h1);
    bus("R10 unmapped", 0, a_direct(12), 2'd3, 0);
    bus("R10 high bits", 1, 16'hC000 | a_direct(8), 2'd3, 64'h7);
    bus("R10 mask0 kept", 0, a_direct(8), 2'd3, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom_range(0, 9));
      int c = int'($urandom_range(0, 5));
      logic [63:0] wd = {$urandom, $urandom};
      logic [1:0] sz = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 2)) : 2'd3;
      logic [15:0] a;
      case ($urandom_range(0, 5))
        0: a = a_direct(0);
        1: a = a_direct(8 + c);
        2: a = a_direct(16 + c);
        3: a = a_bmask(c);
        4: a = a_bpend(c);
        default: a = 16'($urandom);
      endcase
      if (op < 3) dev(1, int'($urandom_range(0, 63)), 0, 0);
      else if (op < 5) dev(0, 0, 1, int'($urandom_range(0, 63)));
      else if (op < 7) bus("R2 rand write", 1, a, sz, wd);
      else bus("R6 rand read", 0, a, sz, 0);
      if (op == 9) chk_irq("R5 rand irq");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule